// File: doc/BRIEF.md
# Programmable Prescaled Down-Counter Timer

This block is a single countdown timer reached through a small word-addressed register port. Software programs a reload value, picks a 16-bit or 32-bit count width, chooses a prescale ratio of 1, 16 or 256, and sets one of three run modes: free-running, periodic or one-shot. The counter moves only on time-base pulses that an external source delivers on `tick_in`. Each pulse is first divided by the prescaler. The count decrements once for every prescaled step.

When the counter expires it sets a raw interrupt flag. The flag stays set until software writes to the interrupt-clear offset. The `irq` output and the masked status register both show the flag gated by the interrupt-enable bit. There are two ways to write the reload value. One also restarts the count at once. The other, the deferred reload register, leaves the running count alone, so the new period starts at the next reload.

Top module: `tmr_core`

## Requirements
- R1: After synchronous reset the control register reads 0x00000020 (interrupt enable only, timer stopped), and the reload value, the count, the raw flag, the masked status and `irq` are all zero.
- R2: The control register bits are: bit 7 run enable, bit 6 periodic, bit 5 interrupt enable, bits 3:2 prescale select, bit 1 32-bit width, bit 0 one-shot. While bit 7 is 0 the count does not change, whatever pulses arrive.
- R3: The word offsets are 0 reload-and-restart, 1 current count, 2 control, 3 interrupt clear, 4 raw status, 5 masked status, 6 deferred reload. A write to offset 0 stores the reload value and loads the count with it in the same cycle. Offsets 0 and 6 both read back the full stored reload value.
- R4: A write to offset 6 stores the reload value and leaves the count unchanged. The new value is used at the next reload.
- R5: On each prescaled step the count decrements by one. A step taken while the count is 1 reloads the count and sets the raw flag, so a reload value N gives a period of N steps. A step at count 0 does the same, except in one-shot mode.
- R6: Any write to offset 3 clears the raw flag.
- R7: The raw status register (bit 0) shows the flag whatever the enable is. The masked status register and `irq` show the flag ANDed with control bit 5.
- R8: In one-shot mode a step at count 1 takes the count to 0 and sets the raw flag. After that, further steps leave the count at 0 and raise no new expiry.
- R9: Prescale select 00 steps on every pulse, 01 on every 16th pulse, 10 on every 256th pulse, and 11 acts as 00. Any write to the control register restarts the pulse division from zero.
- R10: In 16-bit mode only the low 16 bits count and are tested for 1 and 0. The current-count register reads with its upper 16 bits as zero.
- R11: With both periodic and one-shot clear, the timer free-runs and reloads from 0xFFFF in 16-bit mode or from 0xFFFFFFFF in 32-bit mode, ignoring the stored reload value.
- R12: Writes to offset 1 and to unmapped offsets have no effect. Reads of unmapped offsets return 0, and `rdata` is 0 while `rd_en` is low.
- R13: When an expiry and a write to offset 3 fall in the same cycle, the flag ends up set. When a prescaled step and a write to offset 0 fall in the same cycle, the written value wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_in | input | 1 | Time-base pulse, one cycle per count event |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` is 0 when low |
| addr | input | ADDR_W (3) | Word offset |
| wdata | input | CNT_W (32) | Write data |
| rdata | output | CNT_W (32) | Read data, combinational from `addr` |
| irq | output | 1 | Level interrupt: raw flag AND interrupt enable |

## Verification
Two pairs of events can land in the same clock edge, and the bench forces each one. In the first, the count sits at 1 in periodic mode, and at one falling edge the bench drives a time-base pulse together with a write to the interrupt-clear offset. The flag must read as set afterwards, because the expiry wins over the clear. In the second, a pulse coincides with a write to offset 0, and the count must equal the written value rather than the decremented or reloaded one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // register word offsets
   localparam int OFS_LOAD = 0;
   localparam int OFS_CUR  = 1;
   localparam int OFS_CTRL = 2;
   localparam int OFS_ICLR = 3;
   localparam int OFS_RAW  = 4;
   localparam int OFS_MSK  = 5;
   localparam int OFS_BGLD = 6;

   // control bit positions
   localparam int CB_ONESHOT = 0;
   localparam int CB_WIDE    = 1;
   localparam int CB_DIV_LO  = 2;
   localparam int CB_IE      = 5;
   localparam int CB_PER     = 6;
   localparam int CB_EN      = 7;

   localparam int CTRL_W = 8;
   localparam logic [CTRL_W-1:0] CTRL_RST = 8'h20;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int PRE_W = 8
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       clr,
   input  logic       run,
   input  logic       pulse,
   input  logic [1:0] sel,
   output logic       step
);
   generate
      if (PRE_W < 8) begin : g_bad_width
         $error("tmr_prescale: PRE_W must be at least 8 for the 256 ratio");
      end
   endgenerate

   logic [PRE_W-1:0] pc_q;
   logic [PRE_W-1:0] top;

   always_comb begin
      case (sel)
         2'b01:   top = PRE_W'(15);
         2'b10:   top = PRE_W'(255);
         default: top = '0;
      endcase
   end

   assign step = run && pulse && (pc_q == top);

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         pc_q <= '0;
      end else if (run && pulse) begin
         pc_q <= (pc_q == top) ? '0 : pc_q + 1'b1;
      end
   end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int CNT_W    = 32,
   parameter int NARROW_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld_we,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             step,
   input  logic             oneshot,
   input  logic             wide,
   input  logic [CNT_W-1:0] reload_src,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);
   generate
      if (NARROW_W < 1 || NARROW_W > CNT_W) begin : g_bad_width
         $error("tmr_count: NARROW_W must lie in 1..CNT_W");
      end
   endgenerate

   logic [CNT_W-1:0] q;
   logic [CNT_W-1:0] keep_mask;
   logic [CNT_W-1:0] eff;
   logic [CNT_W-1:0] src;
   logic [CNT_W-1:0] nxt;
   logic             at_one;
   logic             at_zero;

   generate
      if (NARROW_W == CNT_W) begin : g_single
         assign keep_mask = '1;
      end else begin : g_dual
         assign keep_mask = wide ? '1
                          : {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
      end
   endgenerate

   assign eff     = q & keep_mask;
   assign src     = reload_src & keep_mask;
   assign at_one  = (eff == CNT_W'(1));
   assign at_zero = (eff == '0);
   assign expire  = step && (at_one || (at_zero && !oneshot));
   assign cnt     = eff;

   always_comb begin
      if (at_one || at_zero) nxt = oneshot ? '0 : src;
      else                   nxt = eff - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)        q <= '0;
      else if (ld_we) q <= ld_val;
      else if (step)  q <= nxt;
   end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
   import tmr_pkg::*;
#(
   parameter int ADDR_W   = 3,
   parameter int CNT_W    = 32,
   parameter int NARROW_W = 16,
   parameter int PRE_W    = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_in,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  wdata,
   output logic [CNT_W-1:0]  rdata,
   output logic              irq
);
   generate
      if (ADDR_W < 3)      begin : g_bad_addr $error("tmr_core: ADDR_W below 3"); end
      if (CNT_W < CTRL_W)  begin : g_bad_cnt  $error("tmr_core: CNT_W below control width"); end
   endgenerate

   logic [CTRL_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  reload_q;
   logic              raw_q;
   logic              step_w;
   logic              expire_w;
   logic [CNT_W-1:0]  cnt_w;
   logic [CNT_W-1:0]  src_w;
   logic              hit_load, hit_ctrl, hit_iclr, hit_bgld;
   logic              wide_w, one_w, en_w, free_w;

   assign hit_load = wr_en && (addr == ADDR_W'(OFS_LOAD));
   assign hit_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
   assign hit_iclr = wr_en && (addr == ADDR_W'(OFS_ICLR));
   assign hit_bgld = wr_en && (addr == ADDR_W'(OFS_BGLD));

   assign wide_w = ctrl_q[CB_WIDE];
   assign one_w  = ctrl_q[CB_ONESHOT];
   assign en_w   = ctrl_q[CB_EN];
   assign free_w = !ctrl_q[CB_PER] && !ctrl_q[CB_ONESHOT];
   assign src_w  = free_w ? '1 : reload_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q   <= CTRL_RST;
         reload_q <= '0;
         raw_q    <= 1'b0;
      end else begin
         if (hit_ctrl)             ctrl_q   <= wdata[CTRL_W-1:0];
         if (hit_load || hit_bgld) reload_q <= wdata;
         if (expire_w)             raw_q    <= 1'b1;
         else if (hit_iclr)        raw_q    <= 1'b0;
      end
   end

   tmr_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst   (rst),
      .clr   (hit_ctrl),
      .run   (en_w),
      .pulse (tick_in),
      .sel   (ctrl_q[CB_DIV_LO+1:CB_DIV_LO]),
      .step  (step_w)
   );

   tmr_count #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .ld_we      (hit_load),
      .ld_val     (wdata),
      .step       (step_w),
      .oneshot    (one_w),
      .wide       (wide_w),
      .reload_src (src_w),
      .cnt        (cnt_w),
      .expire     (expire_w)
   );

   assign irq = raw_q && ctrl_q[CB_IE];

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (addr)
            ADDR_W'(OFS_LOAD), ADDR_W'(OFS_BGLD): rdata = reload_q;
            ADDR_W'(OFS_CUR):  rdata = cnt_w;
            ADDR_W'(OFS_CTRL): rdata = CNT_W'(ctrl_q);
            ADDR_W'(OFS_RAW):  rdata = CNT_W'(raw_q);
            ADDR_W'(OFS_MSK):  rdata = CNT_W'(irq);
            default:           rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/tmr_core_chk.sv
module tmr_core_chk
   import tmr_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [CNT_W-1:0]  wdata,
   input logic              irq,
   input logic              raw,
   input logic              wide,
   input logic              oneshot,
   input logic              en,
   input logic              step,
   input logic              expire,
   input logic [CNT_W-1:0]  cnt
);
   logic w_load, w_cur, w_iclr, w_bgld;
   assign w_load = wr_en && (addr == ADDR_W'(OFS_LOAD));
   assign w_cur  = wr_en && (addr == ADDR_W'(OFS_CUR));
   assign w_iclr = wr_en && (addr == ADDR_W'(OFS_ICLR));
   assign w_bgld = wr_en && (addr == ADDR_W'(OFS_BGLD));

   // R1
   a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!irq && !raw));
   // R3
   a_r3_load_now: assert property (@(posedge clk) disable iff (rst)
      (w_load && wide) |=> (cnt == $past(wdata)));
   // R4
   a_r4_bg_keeps_count: assert property (@(posedge clk) disable iff (rst)
      (w_bgld && !step) |=> $stable(cnt));
   // R5
   a_r5_expire_sets_flag: assert property (@(posedge clk) disable iff (rst)
      expire |=> raw);
   // R6
   a_r6_clear_drops_flag: assert property (@(posedge clk) disable iff (rst)
      (w_iclr && !expire) |=> !raw);
   // R7
   a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
      irq |-> raw);
   // R8
   a_r8_oneshot_holds: assert property (@(posedge clk) disable iff (rst)
      (en && oneshot && cnt == '0 && !wr_en) |=> (cnt == '0));
   // R12
   a_r12_count_read_only: assert property (@(posedge clk) disable iff (rst)
      (w_cur && !step) |=> $stable(cnt));
endmodule

bind tmr_core tmr_core_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .wr_en   (wr_en),
   .addr    (addr),
   .wdata   (wdata),
   .irq     (irq),
   .raw     (raw_q),
   .wide    (wide_w),
   .oneshot (one_w),
   .en      (en_w),
   .step    (step_w),
   .expire  (expire_w),
   .cnt     (cnt_w)
);

// File: tb/tmr_core_test.sv
module tmr_core_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tick_in = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   tmr_core uut (
      .clk(clk), .rst(rst), .tick_in(tick_in), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = 3'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(string tag, int a, logic [31:0] exp);
      rd_en = 1'b1; addr = 3'(a);
      #1;
      chk(tag, rdata, exp);
      rd_en = 1'b0;
   endtask

   task automatic pulses(int n);
      if (n > 0) begin
         @(negedge clk);
         tick_in = 1'b1;
         repeat (n) @(negedge clk);
         tick_in = 1'b0;
      end
   endtask

   task automatic t_reset;
      rd_chk("R1 ctrl", 2, 32'h20);
      rd_chk("R1 reload", 0, 32'h0);
      rd_chk("R1 count", 1, 32'h0);
      rd_chk("R1 raw", 4, 32'h0);
      rd_chk("R1 masked", 5, 32'h0);
      chk("R1 irq", 32'(irq), 32'h0);
   endtask

   task automatic t_periodic;
      wr(0, 32'd5);
      wr(2, 32'hE2);
      pulses(3);
      rd_chk("R5 count after 3", 1, 32'd2);
      pulses(1);
      rd_chk("R5 count at one", 1, 32'd1);
      rd_chk("R5 raw before expiry", 4, 32'h0);
      pulses(1);
      rd_chk("R5 reloaded", 1, 32'd5);
      rd_chk("R5 raw set", 4, 32'h1);
      rd_chk("R7 masked set", 5, 32'h1);
      chk("R7 irq high", 32'(irq), 32'h1);
      wr(3, 32'h0);
      rd_chk("R6 raw cleared", 4, 32'h0);
      chk("R6 irq low", 32'(irq), 32'h0);
   endtask

   task automatic t_disabled;
      wr(2, 32'h62);
      pulses(4);
      rd_chk("R2 stopped count", 1, 32'd5);
   endtask

   task automatic t_mask;
      wr(2, 32'hC2);
      wr(0, 32'd2);
      pulses(2);
      rd_chk("R7 raw unmasked", 4, 32'h1);
      rd_chk("R7 masked off", 5, 32'h0);
      chk("R7 irq masked", 32'(irq), 32'h0);
      wr(2, 32'hE2);
      chk("R7 irq after enable", 32'(irq), 32'h1);
      wr(3, 32'h0);
   endtask

   task automatic t_bg;
      wr(0, 32'd6);
      wr(6, 32'd3);
      rd_chk("R4 count undisturbed", 1, 32'd6);
      rd_chk("R3 load offset value", 0, 32'd3);
      rd_chk("R3 bg offset value", 6, 32'd3);
      pulses(5);
      rd_chk("R4 count at one", 1, 32'd1);
      pulses(1);
      rd_chk("R4 new period used", 1, 32'd3);
      wr(3, 32'h0);
   endtask

   task automatic t_prescale;
      wr(2, 32'hE6);
      wr(0, 32'd4);
      pulses(15);
      rd_chk("R9 div16 no step", 1, 32'd4);
      pulses(1);
      rd_chk("R9 div16 step", 1, 32'd3);
      pulses(10);
      wr(2, 32'hE6);
      pulses(10);
      rd_chk("R9 ctrl write restarts", 1, 32'd3);
      pulses(6);
      rd_chk("R9 div16 second step", 1, 32'd2);
      wr(2, 32'hEA);
      pulses(255);
      rd_chk("R9 div256 no step", 1, 32'd2);
      pulses(1);
      rd_chk("R9 div256 step", 1, 32'd1);
      wr(2, 32'hEE);
      pulses(1);
      rd_chk("R9 sel11 acts as div1", 1, 32'd4);
      wr(3, 32'h0);
   endtask

   task automatic t_oneshot;
      wr(2, 32'hA3);
      wr(0, 32'd2);
      pulses(1);
      rd_chk("R8 count one", 1, 32'd1);
      rd_chk("R8 raw not yet", 4, 32'h0);
      pulses(1);
      rd_chk("R8 count zero", 1, 32'd0);
      rd_chk("R8 raw set", 4, 32'h1);
      wr(3, 32'h0);
      pulses(3);
      rd_chk("R8 stays zero", 1, 32'd0);
      rd_chk("R8 no new expiry", 4, 32'h0);
   endtask

   task automatic t_free;
      wr(2, 32'hA0);
      wr(0, 32'h12340002);
      rd_chk("R10 narrow view", 1, 32'h0002);
      rd_chk("R3 full reload stored", 0, 32'h12340002);
      pulses(1);
      rd_chk("R10 narrow dec", 1, 32'h0001);
      pulses(1);
      rd_chk("R11 free16 reload", 1, 32'h0000FFFF);
      rd_chk("R11 free16 raw", 4, 32'h1);
      pulses(1);
      rd_chk("R10 narrow after wrap", 1, 32'h0000FFFE);
      wr(3, 32'h0);
      wr(2, 32'hA2);
      wr(0, 32'd1);
      pulses(1);
      rd_chk("R11 free32 reload", 1, 32'hFFFFFFFF);
      wr(3, 32'h0);
   endtask

   task automatic t_ro;
      wr(1, 32'h55);
      rd_chk("R12 count write ignored", 1, 32'hFFFFFFFF);
      rd_chk("R12 unmapped read", 7, 32'h0);
      wr(7, 32'h99);
      rd_chk("R12 unmapped write ctrl", 2, 32'hA2);
      rd_chk("R12 unmapped write load", 0, 32'd1);
      rd_en = 1'b0; addr = 3'(2);
      #1;
      chk("R12 idle rdata", rdata, 32'h0);
   endtask

   task automatic t_collide;
      wr(2, 32'hE2);
      wr(0, 32'd1);
      @(negedge clk);
      tick_in = 1'b1; wr_en = 1'b1; addr = 3'(3); wdata = '0;
      @(negedge clk);
      tick_in = 1'b0; wr_en = 1'b0;
      rd_chk("R13 expiry beats clear", 4, 32'h1);
      rd_chk("R13 period-one reload", 1, 32'd1);
      @(negedge clk);
      tick_in = 1'b1; wr_en = 1'b1; addr = 3'(0); wdata = 32'd9;
      @(negedge clk);
      tick_in = 1'b0; wr_en = 1'b0;
      rd_chk("R13 load beats step", 1, 32'd9);
      wr(3, 32'h0);
      chk("R6 irq after clear", 32'(irq), 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_periodic();
      t_disabled();
      t_mask();
      t_bg();
      t_prescale();
      t_oneshot();
      t_free();
      t_ro();
      t_collide();
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule